// File: doc/BRIEF.md
# Power-Management Companion Register Bank

This block is the register file of a power-management companion device. It sits behind a serial bus slave that has already decoded each transfer into a 5-bit register index, a write strobe with 16-bit data, or a read strobe. The bank holds 32 register slots. Only a few of them carry state, and every other slot reads as zero. The bank drives an interrupt line from a status/mask pair and raises a shutdown request when the host writes a watchdog stop code. It also reports a power-key state.

The analog-to-digital converter is not modelled. Each conversion result comes from a table fixed at build time and is selected by a channel number that the host writes. Selecting a channel counts as a finished sample and sets the sample-done interrupt at once. The host clears interrupt status by writing ones to the bits it wants to toggle (XOR acknowledge). A power-key event and a host write in the same cycle both take effect.

Top module: `pmic_regbank`

## Requirements
- R1: After reset the mask (index 0x02) is 0xFFFF, the interrupt status (index 0x01) is 0, the key status register (index 0x16) is 0x0020, the calibration register (index 0x06) is 0x0001, both control registers are 0, `rd_data` is 0 and `irq_o` and `shutdown_req` are low.
- R2: `irq_o` is high exactly when some interrupt status bit is 1 while the same mask bit is 0. The mask is written and read at index 0x02.
- R3: A write to index 0x01 XORs the written data into the interrupt status. A read of index 0x01 returns the status.
- R4: Index 0x00 reads as `ASIC_ID` with bit 7 forced to 1 when `ALT_VARIANT` is set. Writes to index 0x00 have no effect.
- R5: A write to index 0x08 loads the ADC channel from data bits 13:10 and sets interrupt status bit 8 in the same clock edge.
- R6: A read of index 0x08 returns the channel in bits 13:10 and that channel's 10-bit table entry in bits 9:0, with every other bit 0.
- R7: The sample-control register (index 0x09) resets to `SAMPLE_INIT`. A write to it clears every bit that is 1 in the data and leaves the other bits unchanged.
- R8: Writing 0 to index 0x17 while bit 1 of control register 1 (index 0x0D) is 1 makes `shutdown_req` high for exactly the one cycle after the write edge. Any other write leaves it low. Index 0x17 reads as 0.
- R9: A `key_event` pulse sets interrupt status bit 0. It also sets bit 5 of index 0x16 to the inverse of `key_down`, which is 0 while pressed and 1 when released. All other bits of 0x16 read 0.
- R10: The calibration register (0x06) and the two control registers (0x0D, 0x0E) read back the full 16 bits last written.
- R11: Indices 0x03-0x05, 0x07, 0x0A-0x0C and 0x0F-0x1F, except 0x16 and 0x17, read as 0, and writes to them change nothing.
- R12: When a `key_event` and a write to index 0x01 fall in the same cycle, the new status is (old XOR data) with bit 0 set.
- R13: `rd_data` loads the value of the indexed register on the edge where `rd_stb` is high, and holds it at all other times, including across writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_idx | input | 5 | Register index for the current strobe |
| wr_stb | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_stb | input | 1 | Read strobe |
| rd_data | output | 16 | Registered read data |
| key_event | input | 1 | One-cycle power-key change pulse |
| key_down | input | 1 | Key level that goes with `key_event` (1 = pressed) |
| irq_o | output | 1 | Interrupt line |
| shutdown_req | output | 1 | One-cycle shutdown request |

## Verification
The bench builds the bank with `ALT_VARIANT` set, so the variant bit 7 of the ID word is visible. It uses a non-zero `SAMPLE_INIT` of 0xA5C3, which gives the clear-on-write register bits to clear. It also supplies a computed ADC table in which every channel holds a distinct value, so a wrong channel selection or wrong field placement shows up in the readback. Random writes across all 32 indices, combined with same-cycle key events, exercise the merge of status updates, the gating of the watchdog by the control bit, and the slots that must ignore writes.

// File: rtl/pmic_regbank.sv
module pmic_regbank #(
  parameter int              DATA_W      = 16,
  parameter int              NUM_CH      = 16,
  parameter int              RES_W       = 10,
  parameter logic [DATA_W-1:0] ASIC_ID   = 16'h0215,
  parameter bit              ALT_VARIANT = 1'b0,
  parameter logic [DATA_W-1:0] SAMPLE_INIT = '0,
  parameter logic [NUM_CH*RES_W-1:0] ADC_TABLE = {
    10'h000, 10'h000, 10'h330, 10'h3d0, 10'h011, 10'h002, 10'h000, 10'h250,
    10'h011, 10'h011, 10'h3ff, 10'h07b, 10'h165, 10'h0fc, 10'h3c2, 10'h000}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        reg_idx,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] rd_data,
  input  logic              key_event,
  input  logic              key_down,
  output logic              irq_o,
  output logic              shutdown_req
);
  localparam int CH_W      = $clog2(NUM_CH);
  localparam int CH_LSB    = 10;
  localparam int IRQ_KEY   = 0;
  localparam int IRQ_ADC   = 8;
  localparam int KEY_BIT   = 5;
  localparam int WDOG_EN   = 1;
  localparam int VAR_BIT   = 7;

  localparam logic [4:0] IX_ID     = 5'h00;
  localparam logic [4:0] IX_IST    = 5'h01;
  localparam logic [4:0] IX_IMASK  = 5'h02;
  localparam logic [4:0] IX_CAL    = 5'h06;
  localparam logic [4:0] IX_ADC    = 5'h08;
  localparam logic [4:0] IX_SAMPLE = 5'h09;
  localparam logic [4:0] IX_CTRL1  = 5'h0D;
  localparam logic [4:0] IX_CTRL2  = 5'h0E;
  localparam logic [4:0] IX_KSTAT  = 5'h16;
  localparam logic [4:0] IX_WDOG   = 5'h17;

  logic [DATA_W-1:0] irq_st, irq_mask, cal_r, ctrl1_r, ctrl2_r, sample_r;
  logic [DATA_W-1:0] st_next, rd_val, id_val, adc_val, kstat_val;
  logic [CH_W-1:0]   adc_ch;
  logic [RES_W-1:0]  adc_res;
  logic              key_up;

  wire wr_ist    = wr_stb && (reg_idx == IX_IST);
  wire wr_imask  = wr_stb && (reg_idx == IX_IMASK);
  wire wr_cal    = wr_stb && (reg_idx == IX_CAL);
  wire wr_adc    = wr_stb && (reg_idx == IX_ADC);
  wire wr_sample = wr_stb && (reg_idx == IX_SAMPLE);
  wire wr_ctrl1  = wr_stb && (reg_idx == IX_CTRL1);
  wire wr_ctrl2  = wr_stb && (reg_idx == IX_CTRL2);
  wire wr_wdog   = wr_stb && (reg_idx == IX_WDOG);

  always_comb begin
    st_next = irq_st;
    if (wr_ist)    st_next = st_next ^ wr_data;
    if (wr_adc)    st_next[IRQ_ADC] = 1'b1;
    if (key_event) st_next[IRQ_KEY] = 1'b1;
  end

  assign adc_res = ADC_TABLE[int'(adc_ch)*RES_W +: RES_W];

  always_comb begin
    id_val = ASIC_ID;
    if (ALT_VARIANT) id_val[VAR_BIT] = 1'b1;
    adc_val = '0;
    adc_val[CH_LSB +: CH_W] = adc_ch;
    adc_val[RES_W-1:0]      = adc_res;
    kstat_val = '0;
    kstat_val[KEY_BIT] = key_up;
  end

  always_comb begin
    case (reg_idx)
      IX_ID:     rd_val = id_val;
      IX_IST:    rd_val = irq_st;
      IX_IMASK:  rd_val = irq_mask;
      IX_CAL:    rd_val = cal_r;
      IX_ADC:    rd_val = adc_val;
      IX_SAMPLE: rd_val = sample_r;
      IX_CTRL1:  rd_val = ctrl1_r;
      IX_CTRL2:  rd_val = ctrl2_r;
      IX_KSTAT:  rd_val = kstat_val;
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_st       <= '0;
      irq_mask     <= '1;
      cal_r        <= DATA_W'(1);
      ctrl1_r      <= '0;
      ctrl2_r      <= '0;
      sample_r     <= SAMPLE_INIT;
      adc_ch       <= '0;
      key_up       <= 1'b1;
      rd_data      <= '0;
      shutdown_req <= 1'b0;
    end else begin
      irq_st       <= st_next;
      if (wr_imask)  irq_mask <= wr_data;
      if (wr_cal)    cal_r    <= wr_data;
      if (wr_ctrl1)  ctrl1_r  <= wr_data;
      if (wr_ctrl2)  ctrl2_r  <= wr_data;
      if (wr_sample) sample_r <= sample_r & ~wr_data;
      if (wr_adc)    adc_ch   <= wr_data[CH_LSB +: CH_W];
      if (key_event) key_up   <= ~key_down;
      if (rd_stb)    rd_data  <= rd_val;
      shutdown_req <= wr_wdog && (wr_data == '0) && ctrl1_r[WDOG_EN];
    end
  end

  assign irq_o = |(irq_st & ~irq_mask);
endmodule

// File: rtl/pmic_regbank_sva.sv
module pmic_regbank_sva (
  input logic        clk,
  input logic        rst_n,
  input logic [4:0]  reg_idx,
  input logic        wr_stb,
  input logic [15:0] wr_data,
  input logic        rd_stb,
  input logic [15:0] rd_data,
  input logic        key_event,
  input logic        irq_o,
  input logic        shutdown_req,
  input logic [15:0] irq_st
);
  assert_irq_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(wr_stb || key_event));

  assert_adc_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && reg_idx == 5'h08) |=> irq_st[8]);

  assert_wdog_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |-> $past(wr_stb && reg_idx == 5'h17 && wr_data == 16'h0000));

  assert_wdog_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |=> !shutdown_req || $past(wr_stb && reg_idx == 5'h17));

  assert_key_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    key_event |=> irq_st[0]);

  assert_rd_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_data));
endmodule

bind pmic_regbank pmic_regbank_sva u_sva (
  .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .wr_stb(wr_stb),
  .wr_data(wr_data), .rd_stb(rd_stb), .rd_data(rd_data),
  .key_event(key_event), .irq_o(irq_o), .shutdown_req(shutdown_req),
  .irq_st(irq_st)
);

// File: tb/pmic_regbank_tb.sv
`timescale 1ns/1ps
module pmic_regbank_tb;
  function automatic logic [159:0] mk_tab();
    logic [159:0] t;
    for (int c = 0; c < 16; c++) t[c*10 +: 10] = 10'((c*73 + 19) % 1024);
    return t;
  endfunction
  localparam logic [159:0] TAB = mk_tab();

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0, key_event = 1'b0, key_down = 1'b0;
  logic [4:0]  reg_idx = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic irq_o, shutdown_req;

  pmic_regbank #(.ALT_VARIANT(1'b1), .SAMPLE_INIT(16'hA5C3), .ADC_TABLE(TAB)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .wr_stb(wr_stb), .wr_data(wr_data),
    .rd_stb(rd_stb), .rd_data(rd_data), .key_event(key_event), .key_down(key_down),
    .irq_o(irq_o), .shutdown_req(shutdown_req));

  int checks = 0, fails = 0;
  logic [15:0] m_st, m_mask, m_cal, m_cc1, m_cc2, m_samp;
  logic [3:0]  m_ch;
  logic        m_kup;

  task automatic check(input string rq, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [15:0] m_read(input logic [4:0] ix);
    case (ix)
      5'h00: return 16'h0295;
      5'h01: return m_st;
      5'h02: return m_mask;
      5'h06: return m_cal;
      5'h08: return {2'b00, m_ch, TAB[int'(m_ch)*10 +: 10]};
      5'h09: return m_samp;
      5'h0D: return m_cc1;
      5'h0E: return m_cc2;
      5'h16: return {10'h0, m_kup, 5'h0};
      default: return 16'h0000;
    endcase
  endfunction

  function automatic string rq_of(input logic [4:0] ix);
    case (ix)
      5'h00: return "R4";
      5'h01: return "R3";
      5'h02: return "R2";
      5'h06, 5'h0D, 5'h0E: return "R10";
      5'h08: return "R6";
      5'h09: return "R7";
      5'h16: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic op(input bit w, input logic [4:0] ix, input logic [15:0] d,
                    input bit k, input bit kd);
    logic exp_sd;
    wr_stb = w; reg_idx = ix; wr_data = d; key_event = k; key_down = kd;
    exp_sd = w && ix == 5'h17 && d == 16'h0 && m_cc1[1];
    @(posedge clk);
    if (w) begin
      case (ix)
        5'h01: m_st = m_st ^ d;
        5'h02: m_mask = d;
        5'h06: m_cal = d;
        5'h08: begin m_ch = d[13:10]; m_st[8] = 1'b1; end
        5'h09: m_samp = m_samp & ~d;
        5'h0D: m_cc1 = d;
        5'h0E: m_cc2 = d;
        default: ;
      endcase
    end
    if (k) begin m_st[0] = 1'b1; m_kup = ~kd; end
    @(negedge clk);
    wr_stb = 0; key_event = 0;
    check("R2", 16'(irq_o), 16'(|(m_st & ~m_mask)));
    check("R8", 16'(shutdown_req), 16'(exp_sd));
  endtask

  task automatic rd(input logic [4:0] ix, input string rq);
    logic [15:0] e;
    rd_stb = 1; reg_idx = ix; e = m_read(ix);
    @(posedge clk);
    @(negedge clk);
    rd_stb = 0;
    check(rq, rd_data, e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] held;
    void'($urandom(32'd20240611));
    m_st = 0; m_mask = 16'hFFFF; m_cal = 1; m_cc1 = 0; m_cc2 = 0;
    m_samp = 16'hA5C3; m_ch = 0; m_kup = 1;
    repeat (4) @(negedge clk);
    rst_n = 1;
    check("R1", rd_data, 16'h0);
    check("R1", 16'(irq_o), 16'h0);
    check("R1", 16'(shutdown_req), 16'h0);
    rd(5'h02, "R1"); rd(5'h01, "R1"); rd(5'h16, "R1");
    rd(5'h06, "R1"); rd(5'h0D, "R1"); rd(5'h0E, "R1");
    rd(5'h00, "R4");

    op(1, 5'h01, 16'h0001, 0, 0);
    check("R2", 16'(irq_o), 16'h0);
    op(1, 5'h02, 16'hFFFE, 0, 0);
    check("R2", 16'(irq_o), 16'h1);
    op(1, 5'h01, 16'h0005, 0, 0);
    rd(5'h01, "R3");
    op(1, 5'h01, 16'h0004, 0, 0);
    rd(5'h01, "R3");
    op(1, 5'h02, 16'h0000, 0, 0);

    op(1, 5'h08, {2'b11, 4'd5, 10'h3FF}, 0, 0);
    rd(5'h01, "R5");
    rd(5'h08, "R6");
    op(1, 5'h08, {2'b00, 4'd15, 10'h000}, 0, 0);
    rd(5'h08, "R6");

    rd(5'h09, "R7");
    op(1, 5'h09, 16'h0F0F, 0, 0);
    rd(5'h09, "R7");

    op(1, 5'h17, 16'h0000, 0, 0);
    op(1, 5'h0D, 16'h0002, 0, 0);
    op(1, 5'h17, 16'h0010, 0, 0);
    op(1, 5'h17, 16'h0000, 0, 0);
    op(0, 5'h17, 16'h0000, 0, 0);
    rd(5'h17, "R8");

    op(0, 5'h00, 16'h0, 1, 1);
    rd(5'h16, "R9");
    rd(5'h01, "R9");
    op(0, 5'h00, 16'h0, 1, 0);
    rd(5'h16, "R9");

    op(1, 5'h06, 16'hBEEF, 0, 0); rd(5'h06, "R10");
    op(1, 5'h0E, 16'h1234, 0, 0); rd(5'h0E, "R10");

    op(1, 5'h03, 16'hFFFF, 0, 0); rd(5'h03, "R11");
    op(1, 5'h1F, 16'hFFFF, 0, 0); rd(5'h1F, "R11");
    op(1, 5'h00, 16'h1234, 0, 0); rd(5'h00, "R4");

    op(1, 5'h01, m_st | 16'h0081, 1, 1);
    rd(5'h01, "R12");

    rd(5'h06, "R13");
    held = rd_data;
    op(1, 5'h06, 16'h7777, 0, 0);
    check("R13", rd_data, held);

    for (int i = 0; i < 600; i++) begin
      int sel;
      logic [4:0]  ix;
      logic [15:0] d;
      sel = int'($urandom % 5);
      ix  = 5'($urandom);
      d   = (($urandom % 6) == 0) ? 16'h0 : 16'($urandom);
      case (sel)
        0, 1: rd(ix, rq_of(ix));
        2: op(1, ix, d, 0, 0);
        3: op(0, ix, d, 1, 1'($urandom));
        default: begin
          op(1, 5'h01, d, 1, 1'($urandom));
          rd(5'h01, "R12");
        end
      endcase
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule